// File: doc/BRIEF.md
# Multi-Source Wake-Up Controller

This block runs on the slow clock of an always-on power domain. It raises a one-cycle request to restart the core power supply. A request can come from five kinds of source:

- a force-wake pin, which is active low;
- a bank of general wake-up inputs, each with its own enable and its own polarity;
- a real-time clock alarm and a real-time timer alarm, each with its own enable;
- a supply-monitor event.

The force-wake pin has its own debounce counter. The enabled general inputs are first corrected for polarity and then ORed together. That combined condition feeds one shared debounce counter, which has its own period select.

Software sees the block through three plain word ports:

- A mode word, written with a strobe, holds the force-wake enable, both debounce selects and the two alarm enables.
- An input word, also written with a strobe, holds one enable bit and one polarity bit per general input.
- A status word is always visible on the read data port. A read strobe clears it. It holds a sticky force-wake flag and a snapshot of the raw general input levels taken at the last general wake-up.

Top module: `wkc_wake_ctrl`

## Requirements
- R1: A debounce select code picks how many consecutive slow-clock edges the condition must be sampled true before the wake-up fires:
  - code 0 gives 1 edge;
  - codes 1, 2, 3, 4 and 5 give P1, P2, P3, P4 and P5 edges;
  - codes 6 and 7 give P5 edges.
  
  The request goes high in the cycle after the edge where the count completes. If the condition is false at any edge, the count goes back to zero.
- R2: The force-wake condition is `fwake_n` low while mode bit 0 (force-wake enable) is 1. While that bit is 0, the pin never causes a wake-up. Its debounce select is mode bits 3:1.
- R3: A force-wake wake-up sets status bit NUM_IN. That bit stays 1 until a status read clears it.
- R4: General input i is active when input-word bit i (enable) is 1 and the pin level equals input-word bit NUM_IN+i (polarity: 1 means active high, 0 means active low). A disabled input is never active.
- R5: The active general inputs are ORed into one condition for a single shared debouncer, whose select is mode bits 6:4. The count keeps running while the active source hands over from one input to another, provided the ORed condition never drops.
- R6: When the general debouncer fires, status bits NUM_IN-1:0 take the raw levels of all general input pins at that edge. A later general wake-up overwrites this snapshot.
- R7: A rising edge on `rtc_alarm` (when mode bit 7 is 1) or on `rtt_alarm` (when mode bit 8 is 1) raises the request one cycle later. A held alarm gives only one request, and alarms leave the status word unchanged.
- R8: A rising edge on `supmon_evt` always raises the request one cycle later.
- R9: Every wake-up request lasts one cycle. A debouncer that has fired does not fire again until its condition has dropped.
- R10: `stat_rdata` always shows the current status. A cycle with `stat_rd` high clears the status, except for any bit that a new event sets in that same cycle; the new event wins.
- R11: After reset, `wake_req` is 0, the status is 0 and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 9 | Mode word: force-wake enable, force-wake select, general select, clock-alarm enable, timer-alarm enable |
| inp_we | input | 1 | Input word write strobe |
| inp_wdata | input | 2*NUM_IN | Per-input enables (low half) and polarities (high half) |
| stat_rd | input | 1 | Status read strobe, clears the status |
| stat_rdata | output | NUM_IN+1 | Status: input snapshot (low bits) and force-wake flag (top bit) |
| fwake_n | input | 1 | Force-wake pin, active low |
| wk_in | input | NUM_IN | General wake-up input pins |
| rtc_alarm | input | 1 | Real-time clock alarm |
| rtt_alarm | input | 1 | Real-time timer alarm |
| supmon_evt | input | 1 | Supply-monitor event |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench builds the block with NUM_IN at 16 and the five period parameters set to 3, 5, 8, 12 and 17 edges. With these values, every select code, including the two aliased codes, can be swept against an exact latency within a few hundred cycles. Every one of the sixteen inputs is tried at both polarities, and also at its inactive level while the other pins carry a mixed pattern. The short periods also make it cheap to test the corner cases: a condition that drops one edge before completion, a hand-over between inputs during a count, a snapshot being overwritten, and a read that coincides with a new event.

// File: rtl/wkc_pkg.sv
package wkc_pkg;

    localparam int SEL_W  = 3;
    localparam int MODE_W = 9;

    // Mode word layout, LSB first: force enable, force select,
    // general select, clock-alarm enable, timer-alarm enable.
    typedef struct packed {
        logic             rtt_en;
        logic             rtc_en;
        logic [SEL_W-1:0] gi_sel;
        logic [SEL_W-1:0] fw_sel;
        logic             fw_en;
    } mode_t;

    // Number of consecutive true samples needed for a given select code.
    function automatic int unsigned period_of(
        input logic [SEL_W-1:0] sel,
        input int unsigned      p1,
        input int unsigned      p2,
        input int unsigned      p3,
        input int unsigned      p4,
        input int unsigned      p5
    );
        case (sel)
            3'd0:    period_of = 1;
            3'd1:    period_of = p1;
            3'd2:    period_of = p2;
            3'd3:    period_of = p3;
            3'd4:    period_of = p4;
            default: period_of = p5;
        endcase
    endfunction

endpackage

// File: rtl/wkc_debounce.sv
module wkc_debounce #(
    parameter int unsigned P1 = 3,
    parameter int unsigned P2 = 32,
    parameter int unsigned P3 = 512,
    parameter int unsigned P4 = 4096,
    parameter int unsigned P5 = 32768
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cond,
    input  logic [wkc_pkg::SEL_W-1:0] sel,
    output logic                     hit
);

    localparam int CNT_W = $clog2(P5 + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } dbc_t;

    dbc_t             st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        lim     = CNT_W'(wkc_pkg::period_of(sel, P1, P2, P3, P4, P5));
        cnt_inc = st_q.cnt + ONE;
        st_d    = st_q;
        hit     = 1'b0;
        if (!cond) begin
            // Condition lost: restart the count and allow a new wake-up.
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (st_q.armed) begin
            if (cnt_inc >= lim) begin
                hit        = 1'b1;
                st_d.cnt   = '0;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wkc_input_merge.sv
module wkc_input_merge #(
    parameter int NUM_IN = 16
) (
    input  logic [NUM_IN-1:0] pins,
    input  logic [NUM_IN-1:0] en,
    input  logic [NUM_IN-1:0] pol,
    output logic              any_active
);

    logic [NUM_IN-1:0] act;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
        // Level matches polarity and the input is enabled.
        assign act[i] = en[i] & ~(pins[i] ^ pol[i]);
    end

    assign any_active = |act;

endmodule

// File: rtl/wkc_rise.sv
module wkc_rise #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_d, prev_q;

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] = sig[i] & ~prev_q[i];
    end

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/wkc_wake_ctrl.sv
module wkc_wake_ctrl #(
    parameter int          NUM_IN = 16,
    parameter int unsigned P1     = 3,
    parameter int unsigned P2     = 32,
    parameter int unsigned P3     = 512,
    parameter int unsigned P4     = 4096,
    parameter int unsigned P5     = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_we,
    input  logic [8:0]            mode_wdata,
    input  logic                  inp_we,
    input  logic [2*NUM_IN-1:0]   inp_wdata,
    input  logic                  stat_rd,
    output logic [NUM_IN:0]       stat_rdata,
    input  logic                  fwake_n,
    input  logic [NUM_IN-1:0]     wk_in,
    input  logic                  rtc_alarm,
    input  logic                  rtt_alarm,
    input  logic                  supmon_evt,
    output logic                  wake_req
);

    localparam int ALARM_W = 3;

    typedef struct packed {
        wkc_pkg::mode_t    mode;
        logic [NUM_IN-1:0] en;
        logic [NUM_IN-1:0] pol;
        logic [NUM_IN-1:0] snap;
        logic              fw_flag;
        logic              req;
    } ctl_t;

    ctl_t               st_d, st_q;
    logic               fw_cond, gi_cond;
    logic               fw_hit, gi_hit;
    logic [ALARM_W-1:0] alarm_rise;
    logic               fw_en_q, rtc_en_q, rtt_en_q;

    assign fw_en_q  = st_q.mode.fw_en;
    assign rtc_en_q = st_q.mode.rtc_en;
    assign rtt_en_q = st_q.mode.rtt_en;

    assign fw_cond = fw_en_q & ~fwake_n;

    wkc_input_merge #(.NUM_IN(NUM_IN)) u_merge (
        .pins       (wk_in),
        .en         (st_q.en),
        .pol        (st_q.pol),
        .any_active (gi_cond)
    );

    wkc_debounce #(.P1(P1), .P2(P2), .P3(P3), .P4(P4), .P5(P5)) u_fw_dbc (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (fw_cond),
        .sel   (st_q.mode.fw_sel),
        .hit   (fw_hit)
    );

    wkc_debounce #(.P1(P1), .P2(P2), .P3(P3), .P4(P4), .P5(P5)) u_gi_dbc (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (gi_cond),
        .sel   (st_q.mode.gi_sel),
        .hit   (gi_hit)
    );

    wkc_rise #(.W(ALARM_W)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({supmon_evt, rtt_alarm, rtc_alarm}),
        .rise  (alarm_rise)
    );

    always_comb begin
        st_d = st_q;
        if (mode_we) st_d.mode = wkc_pkg::mode_t'(mode_wdata);
        if (inp_we) begin
            st_d.en  = inp_wdata[NUM_IN-1:0];
            st_d.pol = inp_wdata[2*NUM_IN-1:NUM_IN];
        end
        // Read clears first; events in the same cycle override.
        if (stat_rd) begin
            st_d.snap    = '0;
            st_d.fw_flag = 1'b0;
        end
        if (fw_hit) st_d.fw_flag = 1'b1;
        if (gi_hit) st_d.snap    = wk_in;
        st_d.req = fw_hit | gi_hit
                 | (alarm_rise[0] & rtc_en_q)
                 | (alarm_rise[1] & rtt_en_q)
                 |  alarm_rise[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_rdata = {st_q.fw_flag, st_q.snap};
    assign wake_req   = st_q.req;

endmodule

// File: rtl/wkc_wake_ctrl_chk.sv
module wkc_wake_ctrl_chk #(
    parameter int NUM_IN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stat_rd,
    input logic [NUM_IN:0]   stat_rdata,
    input logic              wake_req,
    input logic              rtc_alarm,
    input logic              rtt_alarm,
    input logic              fw_en_q,
    input logic              rtc_en_q,
    input logic              rtt_en_q
);

    AST_FW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[NUM_IN]) |-> $past(fw_en_q)); // R2

    AST_FW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[NUM_IN] && !stat_rd) |=> stat_rdata[NUM_IN]); // R3

    AST_SNAP_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_rdata[NUM_IN-1:0]) |-> (wake_req || $past(stat_rd))); // R6

    AST_RTC_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rtc_alarm) && rtc_en_q) |=> wake_req); // R7

    AST_RTT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rtt_alarm) && rtt_en_q) |=> wake_req); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((stat_rdata == '0) || wake_req)); // R10

endmodule

bind wkc_wake_ctrl wkc_wake_ctrl_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .wake_req   (wake_req),
    .rtc_alarm  (rtc_alarm),
    .rtt_alarm  (rtt_alarm),
    .fw_en_q    (fw_en_q),
    .rtc_en_q   (rtc_en_q),
    .rtt_en_q   (rtt_en_q)
);

// File: tb/tb_wkc_wake_ctrl.sv
`timescale 1ns/1ps
module tb_wkc_wake_ctrl;

    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_we = 1'b0;
    logic [8:0]     mode_wdata = '0;
    logic           inp_we = 1'b0;
    logic [2*N-1:0] inp_wdata = '0;
    logic           stat_rd = 1'b0;
    logic [N:0]     stat_rdata;
    logic           fwake_n = 1'b1;
    logic [N-1:0]   wk_in = '0;
    logic           rtc_alarm = 1'b0;
    logic           rtt_alarm = 1'b0;
    logic           supmon_evt = 1'b0;
    logic           wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wkc_wake_ctrl #(.NUM_IN(N), .P1(3), .P2(5), .P3(8), .P4(12), .P5(17)) dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .inp_we(inp_we), .inp_wdata(inp_wdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .fwake_n(fwake_n), .wk_in(wk_in),
        .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm), .supmon_evt(supmon_evt),
        .wake_req(wake_req)
    );

    function automatic int exp_n(input int sel);
        case (sel)
            0: return 1;
            1: return 3;
            2: return 5;
            3: return 8;
            4: return 12;
            default: return 17;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [8:0] v);
        mode_wdata = v; mode_we = 1'b1;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic write_inp(input logic [N-1:0] en, input logic [N-1:0] pol);
        inp_wdata = {pol, en}; inp_we = 1'b1;
        @(negedge clk); inp_we = 1'b0;
    endtask

    // Returns the cycle (1-based) of the first request, 0 if none.
    task automatic measure(input int maxc, output int lat);
        lat = 0;
        for (int c = 1; c <= maxc; c++) begin
            @(posedge clk); @(negedge clk);
            if (wake_req && lat == 0) lat = c;
        end
    endtask

    task automatic read_status(output logic [N:0] v);
        v = stat_rdata; stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [N:0] sv;
        logic [N-1:0] pat;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(wake_req == 1'b0, "R11 req", wake_req, 0);
        check(stat_rdata == '0, "R11 status", stat_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3/R9/R10: force-wake sweep over all select codes
        for (int sel = 0; sel < 8; sel++) begin
            write_mode({5'b0, 3'(sel), 1'b1});
            fwake_n = 1'b0;
            measure(25, lat);
            check(lat == exp_n(sel), "R1 force latency", lat, exp_n(sel));
            measure(4, lat);
            check(lat == 0, "R9 no refire while held", lat, 0);
            read_status(sv);
            check(sv[N] == 1'b1, "R3 force flag", sv[N], 1);
            read_status(sv);
            check(sv == '0, "R10 cleared by read", sv, 0);
            fwake_n = 1'b1;
            @(negedge clk);
        end

        // R2: disabled force pin
        write_mode(9'b0);
        fwake_n = 1'b0;
        measure(25, lat);
        check(lat == 0, "R2 disabled force", lat, 0);
        check(stat_rdata == '0, "R2 no flag", stat_rdata, 0);
        fwake_n = 1'b1;

        // R1: a one-cycle drop restarts the count (select 3 -> 8)
        write_mode({5'b0, 3'd3, 1'b1});
        fwake_n = 1'b0;
        measure(7, lat);
        check(lat == 0, "R1 no early fire", lat, 0);
        fwake_n = 1'b1;
        @(negedge clk);
        fwake_n = 1'b0;
        measure(20, lat);
        check(lat == 8, "R1 restart after drop", lat, 8);
        fwake_n = 1'b1;
        read_status(sv);

        // R4/R6: every input, both polarities, general select 1 -> 3
        write_mode({2'b0, 3'd1, 3'd0, 1'b0});
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 2; p++) begin
                write_inp(N'(1) << i, p ? (N'(1) << i) : '0);
                pat = 16'hA5C3 ^ 16'(i * 16'h1111);
                pat[i] = (p == 0);          // inactive level
                wk_in = pat;
                measure(5, lat);
                check(lat == 0, "R4 inactive level", lat, 0);
                pat[i] = (p == 1);          // active level
                wk_in = pat;
                measure(6, lat);
                check(lat == 3, "R4 active level latency", lat, 3);
                read_status(sv);
                check(sv == {1'b0, pat}, "R6 snapshot", sv, {1'b0, pat});
                pat[i] = (p == 0);
                wk_in = pat;
                @(negedge clk);
            end
        end

        // R5: hand-over between inputs keeps the shared count (select 2 -> 5)
        write_inp(16'h0003, 16'h0003);
        wk_in = '0;
        write_mode({2'b0, 3'd2, 3'd0, 1'b0});
        read_status(sv);
        wk_in = 16'h0001;
        lat = 0;
        for (int c = 1; c <= 10; c++) begin
            @(posedge clk); @(negedge clk);
            if (wake_req && lat == 0) lat = c;
            if (c == 2) wk_in = 16'h0003;
            if (c == 3) wk_in = 16'h0002;
        end
        check(lat == 5, "R5 shared count across inputs", lat, 5);
        read_status(sv);
        check(sv == {1'b0, 16'h0002}, "R5 snapshot at fire", sv, 17'h2);
        wk_in = '0;
        @(negedge clk);

        // R6: later wake overwrites snapshot (select 0)
        write_mode(9'b0);
        wk_in = 16'h0101;
        measure(2, lat);
        check(lat == 1, "R6 first wake", lat, 1);
        wk_in = 16'h0000;
        @(negedge clk);
        wk_in = 16'h4002;
        measure(2, lat);
        check(lat == 1, "R6 second wake", lat, 1);
        wk_in = '0;
        read_status(sv);
        check(sv == {1'b0, 16'h4002}, "R6 overwrite", sv, 17'h4002);

        // R10: read and new force event in the same cycle
        write_mode(9'b0_0000_0001);
        fwake_n = 1'b0;
        measure(2, lat);
        fwake_n = 1'b1;
        @(negedge clk);
        fwake_n = 1'b0;
        sv = stat_rdata; stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        check(sv[N] == 1'b1, "R10 read value", sv[N], 1);
        check(stat_rdata[N] == 1'b1, "R10 event beats clear", stat_rdata[N], 1);
        check(wake_req == 1'b1, "R10 request on collision", wake_req, 1);
        fwake_n = 1'b1;
        read_status(sv);
        read_status(sv);
        check(sv == '0, "R10 clear after", sv, 0);

        // R7: alarms
        write_mode(9'b0_1000_0000);
        rtc_alarm = 1'b1;
        measure(3, lat);
        check(lat == 1, "R7 rtc wake", lat, 1);
        measure(4, lat);
        check(lat == 0, "R7 rtc held single", lat, 0);
        check(stat_rdata == '0, "R7 no status", stat_rdata, 0);
        rtc_alarm = 1'b0;
        write_mode(9'b0);
        rtc_alarm = 1'b1;
        measure(4, lat);
        check(lat == 0, "R7 rtc disabled", lat, 0);
        rtc_alarm = 1'b0;
        write_mode(9'b1_0000_0000);
        rtt_alarm = 1'b1;
        measure(3, lat);
        check(lat == 1, "R7 rtt wake", lat, 1);
        rtt_alarm = 1'b0;
        write_mode(9'b0);
        rtt_alarm = 1'b1;
        measure(4, lat);
        check(lat == 0, "R7 rtt disabled", lat, 0);
        rtt_alarm = 1'b0;

        // R8: supply monitor, no enable needed
        supmon_evt = 1'b1;
        measure(3, lat);
        check(lat == 1, "R8 supply wake", lat, 1);
        measure(3, lat);
        check(lat == 0, "R8 single pulse", lat, 0);
        supmon_evt = 1'b0;
        check(stat_rdata == '0, "R8 no status", stat_rdata, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule